// File: doc/BRIEF.md
# Stereo Ping-Pong Sample Feeder

This block keeps a stereo frame buffer full for a downstream consumer that reads it in a circle. The buffer holds as many frames as one audio block has samples, and it is treated as two halves. The consumer reads frames through the block's read port. When its read reaches the last frame of a half, the block rewrites that half with fresh frames while the consumer moves on through the other half.

Audio arrives as blocks, one stream for the left channel and one for the right. A block is named by a handle. The sample contents sit in an external store, and the feeder reads them through a per-channel fetch port. Each channel holds up to two pending handles and a read offset into the head one. One refill takes half a block from the head of each channel and writes it as interleaved frames. The block hands a handle back on its release port when that block is used up or pushed out. It also raises a one-cycle request for new audio once per pass through the buffer.

Top module: `stereo_feeder`

## Requirements
- R1: After reset, and with no blocks queued, the block writes no frame, fetches nothing, releases no handle and raises no update request.
- R2: A consumer read of address BLOCK_LEN/2-1 starts a refill of the lower half, addresses 0 to BLOCK_LEN/2-1. A read of address BLOCK_LEN-1 starts a refill of the upper half, addresses BLOCK_LEN/2 to BLOCK_LEN-1.
- R3: A refill writes BLOCK_LEN/2 frames in consecutive cycles, in ascending address order. The first write is visible in the second cycle after the clock edge that sampled the trigger read.
- R4: Each frame word carries the left sample in bits [15:0] and the right sample in bits [31:16]. Frame k of a refill holds sample offset+k of each channel's head block.
- R5: Samples are fetched one frame at a time on a fetch port with one cycle of latency. The fetch presents the head handle and the index offset+k in the cycle before frame k is written.
- R6: If only one channel has a head block, the other channel's 16-bit lane in every frame of that refill is zero, and that channel issues no fetch.
- R7: If neither channel has a head block, the half is written with zero frames, nothing is fetched and no offset changes.
- R8: A channel that supplied data advances its offset by BLOCK_LEN/2 at refill start. On reaching BLOCK_LEN, the offset returns to 0, the head handle is released, and the second slot becomes the head.
- R9: An arriving handle fills an empty head slot with offset 0. If the head slot is full, it fills an empty second slot and leaves the offset unchanged.
- R10: An arrival with both slots full releases the head handle. The second slot moves to the head, the new handle takes the second slot, and the offset is reset to 0.
- R11: The update request is a one-cycle pulse in the cycle after an upper-half refill is triggered, and it is raised for no other refill.
- R12: When a handle arrives in the same cycle as a refill trigger, the refill's queue update is applied first and the arrival second.
- R13: A trigger read that occurs while a refill is still in progress is ignored. It causes no writes, no fetches and no queue change.
- R14: A consumer read returns, one cycle later, the frame most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blkValid | input | 2 | Handle arrival strobe per channel (bit 0 left, bit 1 right) |
| blkHandle | input | 2 x HANDLE_W | Arriving handle per channel |
| relValid | output | 2 | Handle release strobe per channel |
| relHandle | output | 2 x HANDLE_W | Released handle per channel |
| fetchEn | output | 2 | Sample fetch request per channel |
| fetchHandle | output | 2 x HANDLE_W | Block handle being fetched |
| fetchIdx | output | 2 x log2(BLOCK_LEN) | Sample index inside the block |
| fetchData | input | 2 x SAMPLE_W | Fetched sample, valid one cycle after the request |
| consRdEn | input | 1 | Consumer read strobe |
| consAddr | input | log2(BLOCK_LEN) | Consumer frame address |
| consRdData | output | 2 x SAMPLE_W | Frame returned one cycle after a read |
| bufWrEn | output | 1 | Frame write strobe into the buffer |
| bufWrAddr | output | log2(BLOCK_LEN) | Frame write address |
| bufWrData | output | 2 x SAMPLE_W | Frame being written |
| updReq | output | 1 | Request to the producer for new blocks |

## Verification
The hardest situation to reach is a handle arriving on the exact edge where a refill trigger is sampled, with the refill about to finish a head block. In that case the promotion, the release and the placement of the new handle all resolve in one cycle. The stimulus first queues two handles on the right channel and runs one refill, so the right head sits at half a block. It then raises the right-channel arrival in the same cycle as the lower-half trigger read. A second trigger read a few cycles later lands inside the running refill and tests that it is ignored. A separate arrival into a full left queue covers the drop of the oldest handle.

// File: rtl/sfeed_pkg.sv
package sfeed_pkg;

  // Strobes from the control to the datapath, one set per cycle.
  typedef struct packed {
    logic       start;    // refill accepted this cycle
    logic       tgtHigh;  // refill targets the upper half
    logic       issue;    // a frame fetch is issued this cycle
    logic [1:0] laneOn;   // per channel: lane carries data (else zero)
  } feedStrobe_t;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/sfeed_chan_queue.sv
module sfeed_chan_queue #(
  parameter int BLOCK_LEN = 128,
  parameter int HANDLE_W  = 8,
  localparam int OFF_W    = $clog2(BLOCK_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arrive,
  input  logic [HANDLE_W-1:0] arriveHandle,
  input  logic                consume,
  output logic                headValid,
  output logic [HANDLE_W-1:0] headHandle,
  output logic [OFF_W-1:0]    headOff,
  output logic                relValid,
  output logic [HANDLE_W-1:0] relHandle
);

  localparam int HALF  = BLOCK_LEN / 2;
  localparam int SUM_W = OFF_W + 1;

  logic                tailValid;
  logic [HANDLE_W-1:0] tailHandle;

  logic                nHeadV, nTailV, nRel;
  logic [HANDLE_W-1:0] nHeadH, nTailH, nRelH;
  logic [OFF_W-1:0]    nOff;
  logic [SUM_W-1:0]    advSum;

  always_comb begin
    nHeadV = headValid;
    nHeadH = headHandle;
    nTailV = tailValid;
    nTailH = tailHandle;
    nOff   = headOff;
    nRel   = 1'b0;
    nRelH  = headHandle;
    advSum = {1'b0, headOff} + SUM_W'(HALF);

    // refill consumption first
    if (consume && headValid) begin
      if (advSum >= SUM_W'(BLOCK_LEN)) begin
        nOff   = '0;
        nRel   = 1'b1;
        nRelH  = headHandle;
        nHeadV = tailValid;
        nHeadH = tailHandle;
        nTailV = 1'b0;
      end else begin
        nOff = advSum[OFF_W-1:0];
      end
    end

    // then the arrival (a consume-release empties the tail, so no drop follows it)
    if (arrive) begin
      if (!nHeadV) begin
        nHeadV = 1'b1;
        nHeadH = arriveHandle;
        nOff   = '0;
      end else if (!nTailV) begin
        nTailV = 1'b1;
        nTailH = arriveHandle;
      end else begin
        nRel   = 1'b1;
        nRelH  = nHeadH;
        nHeadH = nTailH;
        nTailH = arriveHandle;
        nOff   = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headValid  <= 1'b0;
      headHandle <= '0;
      tailValid  <= 1'b0;
      tailHandle <= '0;
      headOff    <= '0;
      relValid   <= 1'b0;
      relHandle  <= '0;
    end else begin
      headValid  <= nHeadV;
      headHandle <= nHeadH;
      tailValid  <= nTailV;
      tailHandle <= nTailH;
      headOff    <= nOff;
      relValid   <= nRel;
      relHandle  <= nRelH;
    end
  end

  // R9: the second slot is never occupied without a head
  p_tail_needs_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tailValid |-> headValid);

  // R8: offset only ever sits at the start or the middle of a block
  p_offset_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (headOff == OFF_W'(0)) || (headOff == OFF_W'(HALF)));

  // R10: arrival into a full queue releases the old head next cycle
  p_drop_oldest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && headValid && tailValid && !consume)
      |=> (relValid && relHandle == $past(headHandle) && headOff == OFF_W'(0)));

endmodule

// File: rtl/sfeed_ctrl.sv
module sfeed_ctrl
  import sfeed_pkg::*;
#(
  parameter int BLOCK_LEN = 128,
  parameter int HANDLE_W  = 8,
  localparam int OFF_W    = $clog2(BLOCK_LEN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           consRdEn,
  input  logic [OFF_W-1:0]               consAddr,
  input  logic [NUM_CH-1:0]              blkValid,
  input  logic [NUM_CH-1:0][HANDLE_W-1:0] blkHandle,
  output logic [NUM_CH-1:0]              relValid,
  output logic [NUM_CH-1:0][HANDLE_W-1:0] relHandle,
  output logic [NUM_CH-1:0]              fetchEn,
  output logic [NUM_CH-1:0][HANDLE_W-1:0] fetchHandle,
  output logic [NUM_CH-1:0][OFF_W-1:0]   fetchIdx,
  output logic                           updReq,
  output feedStrobe_t                    strobe
);

  localparam int HALF  = BLOCK_LEN / 2;
  localparam int CNT_W = $clog2(HALF + 1);

  logic                            busy;
  logic [CNT_W-1:0]                cnt;
  logic [NUM_CH-1:0]               snapV;
  logic [NUM_CH-1:0][HANDLE_W-1:0] snapH;
  logic [NUM_CH-1:0][OFF_W-1:0]    snapOff;

  logic [NUM_CH-1:0]               headV;
  logic [NUM_CH-1:0][HANDLE_W-1:0] headH;
  logic [NUM_CH-1:0][OFF_W-1:0]    headOff;

  logic hitLow, hitHigh, start, issue;

  assign hitLow  = consRdEn && (consAddr == OFF_W'(HALF - 1));
  assign hitHigh = consRdEn && (consAddr == OFF_W'(BLOCK_LEN - 1));
  assign start   = (hitLow || hitHigh) && !busy;
  assign issue   = busy && (cnt < CNT_W'(HALF));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    sfeed_chan_queue #(
      .BLOCK_LEN (BLOCK_LEN),
      .HANDLE_W  (HANDLE_W)
    ) u_queue (
      .clk          (clk),
      .rst_n        (rst_n),
      .arrive       (blkValid[c]),
      .arriveHandle (blkHandle[c]),
      .consume      (start),
      .headValid    (headV[c]),
      .headHandle   (headH[c]),
      .headOff      (headOff[c]),
      .relValid     (relValid[c]),
      .relHandle    (relHandle[c])
    );

    assign fetchEn[c]     = issue && snapV[c];
    assign fetchHandle[c] = snapH[c];
    assign fetchIdx[c]    = snapOff[c] + OFF_W'(cnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      snapV   <= '0;
      snapH   <= '0;
      snapOff <= '0;
      updReq  <= 1'b0;
    end else begin
      updReq <= start && hitHigh;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        snapV   <= headV;
        snapH   <= headH;
        snapOff <= headOff;
      end else if (busy) begin
        if (issue) cnt <= cnt + 1'b1;
        else       busy <= 1'b0;
      end
    end
  end

  assign strobe.start   = start;
  assign strobe.tgtHigh = hitHigh;
  assign strobe.issue   = issue;
  assign strobe.laneOn  = snapV;

  // R13: once every frame is issued the refill closes on the next edge
  p_busy_ends_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !issue) |=> !busy);

  // R5: fetches only happen inside a running refill
  p_fetch_inside_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|fetchEn) |-> busy);

  // R11: an update request follows a read of the last buffer address
  p_update_from_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    updReq |-> $past(consRdEn && consAddr == OFF_W'(BLOCK_LEN - 1)));

endmodule

// File: rtl/sfeed_dp.sv
module sfeed_dp
  import sfeed_pkg::*;
#(
  parameter int BLOCK_LEN = 128,
  parameter int SAMPLE_W  = 16,
  localparam int OFF_W    = $clog2(BLOCK_LEN),
  localparam int FRAME_W  = 2 * SAMPLE_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  feedStrobe_t                    strobe,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] fetchData,
  input  logic                           consRdEn,
  input  logic [OFF_W-1:0]               consAddr,
  output logic [FRAME_W-1:0]             consRdData,
  output logic                           bufWrEn,
  output logic [OFF_W-1:0]               bufWrAddr,
  output logic [FRAME_W-1:0]             bufWrData
);

  localparam int HALF = BLOCK_LEN / 2;

  logic [OFF_W-1:0]  wrPtr;
  logic              tgtHighQ;
  logic              pend;
  logic [OFF_W-1:0]  pendAddr;
  logic [NUM_CH-1:0] pendLane;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] laneWord;
  logic [FRAME_W-1:0] frameRam [BLOCK_LEN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      tgtHighQ <= 1'b0;
      pend     <= 1'b0;
      pendAddr <= '0;
      pendLane <= '0;
    end else begin
      if (strobe.start) begin
        wrPtr    <= strobe.tgtHigh ? OFF_W'(HALF) : '0;
        tgtHighQ <= strobe.tgtHigh;
      end
      pend <= strobe.issue;
      if (strobe.issue) begin
        pendAddr <= wrPtr;
        pendLane <= strobe.laneOn;
        wrPtr    <= wrPtr + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    assign laneWord[c] = pendLane[c] ? fetchData[c] : '0;
  end

  assign bufWrEn   = pend;
  assign bufWrAddr = pendAddr;
  assign bufWrData = laneWord;  // lane 0 (left) lands in the low half

  always_ff @(posedge clk) begin
    if (pend) frameRam[pendAddr] <= bufWrData;
    if (consRdEn) consRdData <= frameRam[consAddr];
  end

  // R2: every write of a refill stays inside the half it targets
  p_write_in_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (pendAddr[OFF_W-1] == tgtHighQ));

  // R3: writes of one refill advance by one address per cycle
  p_write_ascends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> (pendAddr == $past(pendAddr) + 1'b1));

endmodule

// File: rtl/stereo_feeder.sv
module stereo_feeder
  import sfeed_pkg::*;
#(
  parameter int BLOCK_LEN = 128,
  parameter int SAMPLE_W  = 16,
  parameter int HANDLE_W  = 8,
  localparam int OFF_W    = $clog2(BLOCK_LEN),
  localparam int FRAME_W  = 2 * SAMPLE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                blkValid,
  input  logic [1:0][HANDLE_W-1:0]  blkHandle,
  output logic [1:0]                relValid,
  output logic [1:0][HANDLE_W-1:0]  relHandle,
  output logic [1:0]                fetchEn,
  output logic [1:0][HANDLE_W-1:0]  fetchHandle,
  output logic [1:0][OFF_W-1:0]     fetchIdx,
  input  logic [1:0][SAMPLE_W-1:0]  fetchData,
  input  logic                      consRdEn,
  input  logic [OFF_W-1:0]          consAddr,
  output logic [FRAME_W-1:0]        consRdData,
  output logic                      bufWrEn,
  output logic [OFF_W-1:0]          bufWrAddr,
  output logic [FRAME_W-1:0]        bufWrData,
  output logic                      updReq
);

  feedStrobe_t strobe;

  sfeed_ctrl #(
    .BLOCK_LEN (BLOCK_LEN),
    .HANDLE_W  (HANDLE_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .consRdEn    (consRdEn),
    .consAddr    (consAddr),
    .blkValid    (blkValid),
    .blkHandle   (blkHandle),
    .relValid    (relValid),
    .relHandle   (relHandle),
    .fetchEn     (fetchEn),
    .fetchHandle (fetchHandle),
    .fetchIdx    (fetchIdx),
    .updReq      (updReq),
    .strobe      (strobe)
  );

  sfeed_dp #(
    .BLOCK_LEN (BLOCK_LEN),
    .SAMPLE_W  (SAMPLE_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .fetchData  (fetchData),
    .consRdEn   (consRdEn),
    .consAddr   (consAddr),
    .consRdData (consRdData),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData)
  );

endmodule

// File: tb/stereo_feeder_tb.sv
`timescale 1ns/1ps
module stereo_feeder_tb;

  localparam int BLK  = 128;
  localparam int HALF = BLK / 2;
  localparam int HW   = 8;
  localparam int SW   = 16;
  localparam int OW   = $clog2(BLK);

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0]          blkValid;
  logic [1:0][HW-1:0]  blkHandle;
  logic [1:0]          relValid;
  logic [1:0][HW-1:0]  relHandle;
  logic [1:0]          fetchEn;
  logic [1:0][HW-1:0]  fetchHandle;
  logic [1:0][OW-1:0]  fetchIdx;
  logic [1:0][SW-1:0]  fetchData;
  logic                consRdEn;
  logic [OW-1:0]       consAddr;
  logic [2*SW-1:0]     consRdData;
  logic                bufWrEn;
  logic [OW-1:0]       bufWrAddr;
  logic [2*SW-1:0]     bufWrData;
  logic                updReq;

  always #2.5 clk = ~clk;

  stereo_feeder #(.BLOCK_LEN(BLK), .SAMPLE_W(SW), .HANDLE_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .blkValid(blkValid), .blkHandle(blkHandle),
    .relValid(relValid), .relHandle(relHandle), .fetchEn(fetchEn),
    .fetchHandle(fetchHandle), .fetchIdx(fetchIdx), .fetchData(fetchData),
    .consRdEn(consRdEn), .consAddr(consAddr), .consRdData(consRdData),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .updReq(updReq)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  function automatic logic [SW-1:0] smp(input int h, input int i);
    return SW'((h * 1021 + i * 7 + 3) & 16'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // sample store behind the fetch port: one cycle latency
  always @(posedge clk) begin
    for (int c = 0; c < 2; c++)
      if (fetchEn[c]) fetchData[c] <= smp(int'(fetchHandle[c]), int'(fetchIdx[c]));
  end

  // behavioural reference
  int mV1[2], mH1[2], mV2[2], mH2[2], mOff[2];
  int sV[2], sH[2], sOff[2];
  bit mBusy;
  int mCnt, mBase;
  bit eWr;
  int eWrAddr;
  logic [31:0] eWrData;
  bit [1:0] eRel;
  int eRelH[2];
  bit eUpd;
  bit eConsV;
  logic [31:0] eCons;
  logic [31:0] mBuf[BLK];
  bit mBufOk[BLK];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        mV1[c] = 0; mH1[c] = 0; mV2[c] = 0; mH2[c] = 0; mOff[c] = 0;
        sV[c] = 0; sH[c] = 0; sOff[c] = 0; eRelH[c] = 0;
      end
      for (int a = 0; a < BLK; a++) mBufOk[a] = 0;
      mBusy = 0; mCnt = 0; mBase = 0; eWr = 0; eRel = 0; eUpd = 0; eConsV = 0;
    end else begin
      bit wasBusy;
      bit trig;
      logic [SW-1:0] lw, rw;
      eConsV = consRdEn && mBufOk[consAddr];
      if (consRdEn) eCons = mBuf[consAddr];
      if (eWr) begin mBuf[eWrAddr] = eWrData; mBufOk[eWrAddr] = 1; end
      eWr = 0;
      wasBusy = mBusy;
      if (mBusy) begin
        if (mCnt < HALF) begin
          lw = sV[0] ? smp(sH[0], sOff[0] + mCnt) : '0;
          rw = sV[1] ? smp(sH[1], sOff[1] + mCnt) : '0;
          eWr = 1; eWrAddr = mBase + mCnt; eWrData = {rw, lw};
          mCnt++;
        end else mBusy = 0;
      end
      eRel = 0; eUpd = 0;
      trig = consRdEn && (int'(consAddr) == HALF - 1 || int'(consAddr) == BLK - 1);
      if (!wasBusy && trig) begin
        mBusy = 1; mCnt = 0;
        mBase = (int'(consAddr) == BLK - 1) ? HALF : 0;
        eUpd  = (int'(consAddr) == BLK - 1);
        for (int c = 0; c < 2; c++) begin
          sV[c] = mV1[c]; sH[c] = mH1[c]; sOff[c] = mOff[c];
          if (mV1[c] != 0) begin
            mOff[c] += HALF;
            if (mOff[c] >= BLK) begin
              mOff[c] = 0; eRel[c] = 1; eRelH[c] = mH1[c];
              mV1[c] = mV2[c]; mH1[c] = mH2[c]; mV2[c] = 0;
            end
          end
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (blkValid[c]) begin
          if (mV1[c] == 0) begin mV1[c] = 1; mH1[c] = int'(blkHandle[c]); mOff[c] = 0; end
          else if (mV2[c] == 0) begin mV2[c] = 1; mH2[c] = int'(blkHandle[c]); end
          else begin
            eRel[c] = 1; eRelH[c] = mH1[c];
            mH1[c] = mH2[c]; mH2[c] = int'(blkHandle[c]); mOff[c] = 0;
          end
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bufWrEn == eWr, "R3 R13 write strobe", 32'(bufWrEn), 32'(eWr));
      if (eWr) begin
        chk(int'(bufWrAddr) == eWrAddr, "R2 R3 write address", 32'(bufWrAddr), 32'(eWrAddr));
        chk(bufWrData == eWrData, "R4 R6 R7 frame data", bufWrData, eWrData);
      end
      chk(updReq == eUpd, "R11 update request", 32'(updReq), 32'(eUpd));
      for (int c = 0; c < 2; c++) begin
        bit fe;
        fe = mBusy && (mCnt < HALF) && (sV[c] != 0);
        chk(relValid[c] == eRel[c], "R8 R10 R12 release strobe", 32'(relValid[c]), 32'(eRel[c]));
        if (eRel[c])
          chk(int'(relHandle[c]) == eRelH[c], "R8 R10 R12 release handle", 32'(relHandle[c]), 32'(eRelH[c]));
        chk(fetchEn[c] == fe, "R5 R6 R7 fetch strobe", 32'(fetchEn[c]), 32'(fe));
        if (fe) begin
          chk(int'(fetchHandle[c]) == sH[c], "R5 R9 fetch handle", 32'(fetchHandle[c]), 32'(sH[c]));
          chk(int'(fetchIdx[c]) == sOff[c] + mCnt, "R5 R8 fetch index", 32'(fetchIdx[c]), 32'(sOff[c] + mCnt));
        end
      end
      if (eConsV) chk(consRdData == eCons, "R14 consumer read", consRdData, eCons);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      failures++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int c, input int h);
    blkValid[c] = 1'b1; blkHandle[c] = HW'(h);
    @(negedge clk);
    blkValid = '0;
  endtask

  task automatic consRead(input int a);
    consRdEn = 1'b1; consAddr = OW'(a);
    @(negedge clk);
    consRdEn = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; blkValid = '0; blkHandle = '0; consRdEn = 1'b0; consAddr = '0; fetchData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    chk(bufWrEn == 1'b0, "R1 write idle", 32'(bufWrEn), 32'h0);
    chk(relValid == 2'b00, "R1 release idle", 32'(relValid), 32'h0);
    chk(fetchEn == 2'b00, "R1 fetch idle", 32'(fetchEn), 32'h0);
    chk(updReq == 1'b0, "R1 update idle", 32'(updReq), 32'h0);
    rst_n = 1'b1;
    idle(3);

    // R7: both channels empty, lower half zeroed
    consRead(HALF - 1);
    idle(80);
    // R6 R11: left only, upper half, update request
    push(0, 5);
    consRead(BLK - 1);
    idle(80);
    // R8: second half of block 5 then release
    consRead(HALF - 1);
    idle(80);
    // R9: fill both slots of both channels
    push(0, 10); push(1, 20); push(0, 11); push(1, 21);
    consRead(BLK - 1);
    idle(80);
    // R10: overflow on the left drops handle 10
    push(0, 12);
    idle(3);
    // R12: arrival on the right in the trigger cycle
    blkValid[1] = 1'b1; blkHandle[1] = HW'(22);
    consRead(HALF - 1);
    blkValid = '0;
    idle(5);
    // R13: trigger inside a running refill is ignored
    consRead(BLK - 1);
    idle(80);
    consRead(BLK - 1);
    idle(80);
    // R14: sweep the consumer port over both halves
    for (int a = 0; a < BLK; a += 5) consRead(a);
    idle(3);
    // R10 on the right while a refill runs
    consRead(HALF - 1);
    push(1, 23); push(1, 24); push(1, 25);
    idle(80);
    for (int a = 1; a < BLK; a += 11) consRead(a);
    idle(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule